// File: doc/BRIEF.md
# Shared Decode Queue with Protocol Reservation

This block is an in-order instruction decode queue that several application threads and a single protocol thread write into. Entries leave strictly in arrival order, whichever thread wrote them. Each stored entry keeps the identifier of the thread that wrote it.

Admission depends on the class of the writer. Application threads can fill the queue only up to one slot below its physical depth. The protocol thread can use every slot. An application miss can stall the front end while it waits for the protocol thread to service it. The held-back slot means a protocol instruction can always get in, so that stall cannot turn into a deadlock.

The queue has one write port, which takes at most one entry per cycle, and one read port. Thread identifiers 0 to NUM_APP-1 are application threads and identifier NUM_APP is the protocol thread. A synchronous flush empties the queue in one cycle.

Top module: `shared_dq`

## Requirements
- R1: After reset the queue is empty: deq_valid_o is 0 and both app_ready_o and prot_ready_o are 1.
- R2: app_ready_o is 1 exactly when fewer than DEPTH-1 (7) entries are held.
- R3: prot_ready_o is 1 exactly when fewer than DEPTH (8) entries are held.
- R4: An enqueue with an application thread ID (enq_tid_i below NUM_APP) is dropped when app_ready_o is 0. The occupancy and the dequeue order are unchanged.
- R5: An enqueue with the protocol thread ID (enq_tid_i equal to NUM_APP, default 4) is accepted into the last free slot while application threads hold DEPTH-1 entries.
- R6: Entries dequeue in FIFO order across all threads. deq_tid_o and deq_data_o present the ID and payload that were written with each entry.
- R7: An accepted enqueue and a dequeue in the same cycle leave the occupancy unchanged.
- R8: flush_i empties the queue at the next clock edge and drops any enqueue or dequeue in the same cycle. No entry written before the flush is ever dequeued afterwards.
- R9: Asserting deq_ready_i while the queue is empty has no effect. A following single enqueue yields exactly one dequeued entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| flush_i | input | 1 | Synchronous empty of the whole queue |
| enq_valid_i | input | 1 | Enqueue request |
| enq_tid_i | input | TID_W (3) | Writer thread ID; NUM_APP marks the protocol thread |
| enq_data_i | input | DATA_W (16) | Entry payload |
| app_ready_o | output | 1 | Application threads may enqueue |
| prot_ready_o | output | 1 | Protocol thread may enqueue |
| deq_valid_o | output | 1 | Head entry is valid |
| deq_tid_o | output | TID_W (3) | Thread ID of the head entry |
| deq_data_o | output | DATA_W (16) | Payload of the head entry |
| deq_ready_i | input | 1 | Consumer takes the head entry |

## Verification
The bench fills the queue with application entries up to the 7-slot limit and then offers one more application entry. A design that ignored the reservation would take that entry and lock out the protocol thread. The bench then checks that a protocol entry still lands in the eighth slot, and that a further protocol push at 8 entries is dropped, which shows up as a drain count above 8 or an order error. It also drives a run of simultaneous push and pop cycles, a flush with a concurrent push, and pops on an empty queue. A counter that was off by one, failed to clear, or wrapped under zero would show as a wrong drain count, a stale entry after the flush, or a valid signal that stays stuck high.

// File: rtl/sdq_pkg.sv
package sdq_pkg;
  typedef enum logic {CLS_APP = 1'b0, CLS_PROT = 1'b1} thr_cls_e;
endpackage

// File: rtl/sdq_admit.sv
module sdq_admit #(
  parameter int DEPTH   = 8,
  parameter int RESERVE = 1,
  parameter int NUM_APP = 4,
  localparam int TID_W  = $clog2(NUM_APP + 1),
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic [CNT_W-1:0] count_i,
  input  logic             enq_valid_i,
  input  logic [TID_W-1:0] enq_tid_i,
  input  logic             flush_i,
  output logic             app_ready_o,
  output logic             prot_ready_o,
  output logic             push_o
);
  import sdq_pkg::*;

  localparam logic [CNT_W-1:0] AppLimit  = CNT_W'(DEPTH - RESERVE);
  localparam logic [CNT_W-1:0] ProtLimit = CNT_W'(DEPTH);
  localparam logic [TID_W-1:0] ProtTid   = TID_W'(NUM_APP);

  thr_cls_e cls;

  always_comb begin
    cls          = (enq_tid_i == ProtTid) ? CLS_PROT : CLS_APP;
    app_ready_o  = count_i < AppLimit;
    prot_ready_o = count_i < ProtLimit;
    push_o       = enq_valid_i && !flush_i &&
                   ((cls == CLS_PROT) ? prot_ready_o : app_ready_o);
  end
endmodule

// File: rtl/sdq_occ.sv
module sdq_occ #(
  parameter int DEPTH  = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             push_i,
  input  logic             pop_i,
  output logic [CNT_W-1:0] count_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                count_o <= '0;
    else if (flush_i)           count_o <= '0;
    else if (push_i && !pop_i)  count_o <= count_o + 1'b1;
    else if (pop_i && !push_i)  count_o <= count_o - 1'b1;
  end
endmodule

// File: rtl/sdq_store.sv
module sdq_store #(
  parameter int DEPTH  = 8,
  parameter int ENT_W  = 19,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic [ENT_W-1:0] wdata_i,
  output logic [ENT_W-1:0] head_o
);
  localparam logic [PTR_W-1:0] LastIdx = PTR_W'(DEPTH - 1);

  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [ENT_W-1:0] mem [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else if (flush_i) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      if (push_i) wr_ptr <= (wr_ptr == LastIdx) ? '0 : wr_ptr + 1'b1;
      if (pop_i)  rd_ptr <= (rd_ptr == LastIdx) ? '0 : rd_ptr + 1'b1;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk_i) begin
      if (push_i && wr_ptr == PTR_W'(g)) mem[g] <= wdata_i;
    end
  end

  assign head_o = mem[rd_ptr];
endmodule

// File: rtl/shared_dq.sv
module shared_dq #(
  parameter int DEPTH   = 8,
  parameter int RESERVE = 1,
  parameter int NUM_APP = 4,
  parameter int DATA_W  = 16,
  localparam int TID_W  = $clog2(NUM_APP + 1),
  localparam int CNT_W  = $clog2(DEPTH + 1),
  localparam int ENT_W  = TID_W + DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              enq_valid_i,
  input  logic [TID_W-1:0]  enq_tid_i,
  input  logic [DATA_W-1:0] enq_data_i,
  output logic              app_ready_o,
  output logic              prot_ready_o,
  output logic              deq_valid_o,
  output logic [TID_W-1:0]  deq_tid_o,
  output logic [DATA_W-1:0] deq_data_o,
  input  logic              deq_ready_i
);
  logic [CNT_W-1:0] count;
  logic             push, pop;
  logic [ENT_W-1:0] head;

  assign deq_valid_o = count != '0;
  assign pop         = deq_valid_o && deq_ready_i && !flush_i;

  sdq_admit #(.DEPTH(DEPTH), .RESERVE(RESERVE), .NUM_APP(NUM_APP)) u_admit (
    .count_i     (count),
    .enq_valid_i (enq_valid_i),
    .enq_tid_i   (enq_tid_i),
    .flush_i     (flush_i),
    .app_ready_o (app_ready_o),
    .prot_ready_o(prot_ready_o),
    .push_o      (push)
  );

  sdq_occ #(.DEPTH(DEPTH)) u_occ (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .flush_i(flush_i),
    .push_i (push),
    .pop_i  (pop),
    .count_o(count)
  );

  sdq_store #(.DEPTH(DEPTH), .ENT_W(ENT_W)) u_store (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .flush_i(flush_i),
    .push_i (push),
    .pop_i  (pop),
    .wdata_i({enq_tid_i, enq_data_i}),
    .head_o (head)
  );

  assign {deq_tid_o, deq_data_o} = head;
endmodule

// File: rtl/sdq_chk.sv
module sdq_chk #(
  parameter int DEPTH   = 8,
  parameter int RESERVE = 1,
  parameter int NUM_APP = 4,
  localparam int TID_W  = $clog2(NUM_APP + 1),
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             flush_i,
  input logic             enq_valid_i,
  input logic [TID_W-1:0] enq_tid_i,
  input logic             app_ready_o,
  input logic             prot_ready_o,
  input logic             deq_valid_o,
  input logic             deq_ready_i
);
  localparam logic [TID_W-1:0] ProtTid = TID_W'(NUM_APP);

  logic             is_prot, acc, popd;
  logic [CNT_W+1:0] shadow;

  assign is_prot = enq_tid_i == ProtTid;
  assign acc  = enq_valid_i && !flush_i && (is_prot ? prot_ready_o : app_ready_o);
  assign popd = deq_valid_o && deq_ready_i && !flush_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       shadow <= '0;
    else if (flush_i)  shadow <= '0;
    else               shadow <= shadow + (CNT_W+2)'(acc) - (CNT_W+2)'(popd);
  end

  // R3
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shadow <= (CNT_W+2)'(DEPTH) && (prot_ready_o == (shadow != (CNT_W+2)'(DEPTH))));

  // R2
  app_limit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    app_ready_o == (shadow < (CNT_W+2)'(DEPTH - RESERVE)));

  // R1
  valid_track_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    deq_valid_o == (shadow != '0));

  // R7
  steady_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && popd) |=> ($stable(app_ready_o) && $stable(prot_ready_o) && deq_valid_o));

  // R8
  flush_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (!deq_valid_o && app_ready_o && prot_ready_o));

  // R9
  empty_pop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!deq_valid_o && !enq_valid_i) |=> !deq_valid_o);
endmodule

bind shared_dq sdq_chk #(.DEPTH(DEPTH), .RESERVE(RESERVE), .NUM_APP(NUM_APP)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .flush_i     (flush_i),
  .enq_valid_i (enq_valid_i),
  .enq_tid_i   (enq_tid_i),
  .app_ready_o (app_ready_o),
  .prot_ready_o(prot_ready_o),
  .deq_valid_o (deq_valid_o),
  .deq_ready_i (deq_ready_i)
);

// File: tb/shared_dq_tb.sv
module shared_dq_tb;
  localparam int DEPTH = 8;
  localparam int NUM_APP = 4;
  localparam int DATA_W = 16;
  localparam int TID_W = 3;
  localparam logic [TID_W-1:0] PROT = 3'd4;

  logic clk = 0, rst_ni = 0;
  logic flush_i = 0, enq_valid_i = 0, deq_ready_i = 0;
  logic [TID_W-1:0] enq_tid_i = '0;
  logic [DATA_W-1:0] enq_data_i = '0;
  logic app_ready_o, prot_ready_o, deq_valid_o;
  logic [TID_W-1:0] deq_tid_o;
  logic [DATA_W-1:0] deq_data_o;

  int n_chk = 0, n_fail = 0;
  logic [TID_W+DATA_W-1:0] model[$];

  always #2ns clk = ~clk;

  shared_dq #(.DEPTH(DEPTH), .NUM_APP(NUM_APP), .DATA_W(DATA_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .flush_i(flush_i),
    .enq_valid_i(enq_valid_i), .enq_tid_i(enq_tid_i), .enq_data_i(enq_data_i),
    .app_ready_o(app_ready_o), .prot_ready_o(prot_ready_o),
    .deq_valid_o(deq_valid_o), .deq_tid_o(deq_tid_o), .deq_data_o(deq_data_o),
    .deq_ready_i(deq_ready_i)
  );

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // one clock: drive at negedge, model the edge, return at next negedge
  task automatic cyc(bit ev, logic [TID_W-1:0] tid, logic [DATA_W-1:0] d, bit dr, bit fl);
    int cnt = model.size();
    bit acc = ev && !fl && ((tid == PROT) ? (cnt < DEPTH) : (cnt < DEPTH - 1));
    bit pop = dr && !fl && cnt > 0;
    if (pop) begin
      chk("R6 tid", int'(deq_tid_o), int'(model[0][DATA_W+:TID_W]));
      chk("R6 data", int'(deq_data_o), int'(model[0][DATA_W-1:0]));
    end
    enq_valid_i = ev; enq_tid_i = tid; enq_data_i = d; deq_ready_i = dr; flush_i = fl;
    @(negedge clk);
    if (fl) model.delete();
    else begin
      if (pop) void'(model.pop_front());
      if (acc) model.push_back({tid, d});
    end
    enq_valid_i = 0; deq_ready_i = 0; flush_i = 0;
  endtask

  task automatic drain(string req, int exp_n);
    int n = 0;
    while (deq_valid_o && n < 20) begin
      cyc(0, '0, '0, 1, 0);
      n++;
    end
    chk(req, n, exp_n);
  endtask

  task automatic t_reset();
    chk("R1 valid", deq_valid_o, 0);
    chk("R1 app_ready", app_ready_o, 1);
    chk("R1 prot_ready", prot_ready_o, 1);
  endtask

  task automatic t_reserve();
    for (int i = 0; i < 7; i++) cyc(1, TID_W'(i % NUM_APP), DATA_W'(16'h100 + i), 0, 0);
    chk("R2 app_ready at 7", app_ready_o, 0);
    chk("R3 prot_ready at 7", prot_ready_o, 1);
    cyc(1, 3'd1, 16'hdead, 0, 0);
    chk("R4 app push dropped", prot_ready_o, 1);
    cyc(1, PROT, 16'h0abc, 0, 0);
    chk("R5 prot takes last slot", prot_ready_o, 0);
    cyc(1, PROT, 16'hbeef, 0, 0);
    drain("R3 drain count after full", 8);
  endtask

  task automatic t_simul();
    for (int i = 0; i < 3; i++) cyc(1, PROT - 3'(i + 1), DATA_W'(16'h200 + i), 0, 0);
    for (int i = 0; i < 5; i++) begin
      cyc(1, (i % 2) ? PROT : 3'd2, DATA_W'(16'h300 + i), 1, 0);
      chk("R7 app_ready", app_ready_o, 1);
    end
    drain("R7 occupancy", 3);
  endtask

  task automatic t_flush();
    for (int i = 0; i < 5; i++) cyc(1, 3'd0, DATA_W'(16'h400 + i), 0, 0);
    cyc(1, PROT, 16'h0f0f, 1, 1);
    chk("R8 valid after flush", deq_valid_o, 0);
    chk("R8 app_ready after flush", app_ready_o, 1);
    cyc(1, 3'd3, 16'h0555, 0, 0);
    drain("R8 post-flush count", 1);
  endtask

  task automatic t_empty_pop();
    for (int i = 0; i < 3; i++) cyc(0, '0, '0, 1, 0);
    chk("R9 valid stays low", deq_valid_o, 0);
    cyc(1, PROT, 16'h0777, 0, 0);
    drain("R9 single entry", 1);
    chk("R9 empty again", deq_valid_o, 0);
  endtask

  initial begin
    #100us;
    n_fail++; n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    t_reset();
    t_reserve();
    t_simul();
    t_flush();
    t_empty_pop();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule